// File: doc/BRIEF.md
# Subroutine Return-and-Skip Sequencer

This block carries out one control-flow operation of a 4-bit processor: it returns from a subroutine and skips the first instruction at the return point. A caller raises a start pulse with a 12-bit opcode. It also presents the current 8-bit stack pointer and the four status flags. If the opcode matches the return-and-skip encoding, the sequencer reads three nibbles from the stack memory. It uses a single synchronous read port with one cycle of latency. The three nibbles rebuild a split program counter, made of a 4-bit page and an 8-bit step. The sequencer then adds one to the step, and leaves the stack pointer advanced by three.

The run always lasts a fixed twelve cycles. A busy output covers the whole run, and a single-cycle done pulse marks its last cycle. The restored page, step, stack pointer and unchanged flags are held on the outputs until the next accepted start.

The controller walks these named states:
- IDLE waits for a start.
- DECODE is the first busy cycle.
- RD0, RD1 and RD2 issue the three reads. RD1 and RD2 also capture the data of the previous read.
- LAST captures the page and advances the stack pointer.
- SKIP increments the step.
- HOLD pads the run to the fixed length.
- FIN raises done and returns to IDLE.

Top module: `retskip_seq`

## Requirements
- R1: After reset, busy, done and the read strobe are low, and sp_o, page_o, step_o and flags_o are all zero.
- R2: A start in IDLE with opcode 0xFDE is accepted, and busy is high in the next cycle.
- R3: A start in IDLE with any other opcode is ignored. Busy and the read strobe stay low, and every result output keeps its value.
- R4: The read strobe is high in exactly the 2nd, 3rd and 4th cycles after acceptance. In those cycles the address is sp, sp+1 and sp+2, taken modulo 256.
- R5: The low nibble of the step comes from the word at sp, the high nibble from the word at sp+1, and the page from the word at sp+2.
- R6: At completion, sp_o equals the accepted stack pointer plus 3, modulo 256.
- R7: The restored step is incremented by one. It wraps from 0xFF to 0x00, and the wrap leaves the page unchanged.
- R8: Done is a single-cycle pulse in the 12th cycle after acceptance. Busy is high in cycles 1 to 12 and low in cycle 13.
- R9: flags_o takes the flags presented at acceptance and does not change while busy.
- R10: A start, or a change of sp_i, while busy has no effect on the run or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| opcode_i | input | 12 | Opcode presented with start |
| sp_i | input | 8 | Stack pointer presented with start |
| flags_i | input | 4 | Status flags presented with start |
| mem_rd_o | output | 1 | Stack memory read strobe |
| mem_addr_o | output | 8 | Stack memory address |
| mem_rdata_i | input | 4 | Read data, valid one cycle after the strobe |
| busy_o | output | 1 | High during the run |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 8 | Stack pointer after the run |
| page_o | output | 4 | Restored page |
| step_o | output | 8 | Restored and incremented step |
| flags_o | output | 4 | Flags carried through unchanged |

## Verification
Cycle 0 is the clock edge that accepts the start. The bench samples busy, done, the read strobe and the address on the falling edge of each of cycles 1 to 13. It expects the reads in cycles 2 to 4 only, done in cycle 12 only, and busy to drop in cycle 13. Page, step, stack pointer and flags all settle before done. The bench checks them in cycle 12 and again in cycle 13. It also checks that an ignored start leaves every output unchanged over the following three cycles.

// File: rtl/retskip_pkg.sv
package retskip_pkg;

    localparam int unsigned OPC_W   = 12;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned STEP_W  = 8;
    localparam logic [OPC_W-1:0] OPC_RETSKIP = 12'hFDE;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RD0,
        ST_RD1,
        ST_RD2,
        ST_LAST,
        ST_SKIP,
        ST_HOLD,
        ST_FIN
    } rs_state_e;

    typedef struct packed {
        logic       take;
        logic       rd;
        logic [1:0] rd_off;
        logic       cap_lo;
        logic       cap_hi;
        logic       cap_pg;
        logic       sp_adv;
        logic       skip;
    } rs_ctl_t;

endpackage

// File: rtl/retskip_ctrl.sv
module retskip_ctrl
    import retskip_pkg::*;
#(
    parameter int unsigned LATENCY = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [OPC_W-1:0]     opcode_i,
    output rs_ctl_t              ctl_o,
    output logic                 busy_o,
    output logic                 done_o
);

    localparam int unsigned HOLD_CYC = LATENCY - 7;
    localparam int unsigned CW       = $clog2(LATENCY);

    rs_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            accept;

    assign accept = (state_q == ST_IDLE) && start_i && (opcode_i == OPC_RETSKIP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q != ST_HOLD) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_DECODE;
            ST_DECODE: state_d = ST_RD0;
            ST_RD0:    state_d = ST_RD1;
            ST_RD1:    state_d = ST_RD2;
            ST_RD2:    state_d = ST_LAST;
            ST_LAST:   state_d = ST_SKIP;
            ST_SKIP:   state_d = ST_HOLD;
            ST_HOLD:   if (cnt_q == CW'(HOLD_CYC - 1)) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl_o      = '0;
        ctl_o.take = accept;
        unique case (state_q)
            ST_RD0:  begin ctl_o.rd = 1'b1; ctl_o.rd_off = 2'd0; end
            ST_RD1:  begin ctl_o.rd = 1'b1; ctl_o.rd_off = 2'd1; ctl_o.cap_lo = 1'b1; end
            ST_RD2:  begin ctl_o.rd = 1'b1; ctl_o.rd_off = 2'd2; ctl_o.cap_hi = 1'b1; end
            ST_LAST: begin ctl_o.cap_pg = 1'b1; ctl_o.sp_adv = 1'b1; end
            ST_SKIP: ctl_o.skip = 1'b1;
            default: ;
        endcase
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_FIN);
    end

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && opcode_i == OPC_RETSKIP) |=> busy_o);
    // R3
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && opcode_i != OPC_RETSKIP) |=> !busy_o);
    // R4
    rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.rd |-> busy_o);

endmodule

// File: rtl/retskip_spunit.sv
module retskip_spunit
    import retskip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rs_ctl_t           ctl_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] sp_o
);

    logic [ADDR_W-1:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            sp_q <= '0;
        else if (ctl_i.take)   sp_q <= sp_i;
        else if (ctl_i.sp_adv) sp_q <= sp_q + ADDR_W'(3);
    end

    always_comb begin
        mem_rd_o   = ctl_i.rd;
        mem_addr_o = sp_q + ADDR_W'(ctl_i.rd_off);
        sp_o       = sp_q;
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 8'd1));

endmodule

// File: rtl/retskip_pcreg.sv
module retskip_pcreg
    import retskip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rs_ctl_t           ctl_i,
    input  logic              busy_i,
    input  logic [NIB_W-1:0]  rdata_i,
    input  logic [3:0]        flags_i,
    output logic [NIB_W-1:0]  page_o,
    output logic [STEP_W-1:0] step_o,
    output logic [3:0]        flags_o
);

    logic [NIB_W-1:0]  page_q;
    logic [STEP_W-1:0] step_q;
    logic [3:0]        flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (ctl_i.cap_lo) begin
            step_q[NIB_W-1:0] <= rdata_i;
        end else if (ctl_i.cap_hi) begin
            step_q[STEP_W-1:NIB_W] <= rdata_i;
        end else if (ctl_i.skip) begin
            step_q <= step_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            page_q <= '0;
        else if (ctl_i.cap_pg) page_q <= rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flags_q <= '0;
        else if (ctl_i.take) flags_q <= flags_i;
    end

    assign page_o  = page_q;
    assign step_o  = step_q;
    assign flags_o = flags_q;

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(flags_o));
    // R7
    skip_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.skip |=> (page_o == $past(page_o)));

endmodule

// File: rtl/retskip_seq.sv
module retskip_seq
    import retskip_pkg::*;
#(
    parameter int unsigned LATENCY = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [11:0] opcode_i,
    input  logic [7:0]  sp_i,
    input  logic [3:0]  flags_i,
    output logic        mem_rd_o,
    output logic [7:0]  mem_addr_o,
    input  logic [3:0]  mem_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [7:0]  sp_o,
    output logic [3:0]  page_o,
    output logic [7:0]  step_o,
    output logic [3:0]  flags_o
);

    rs_ctl_t ctl;

    retskip_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .opcode_i (opcode_i),
        .ctl_o    (ctl),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    retskip_spunit u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (ctl),
        .sp_i       (sp_i),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .sp_o       (sp_o)
    );

    retskip_pcreg u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (ctl),
        .busy_i  (busy_o),
        .rdata_i (mem_rdata_i),
        .flags_i (flags_i),
        .page_o  (page_o),
        .step_o  (step_o),
        .flags_o (flags_o)
    );

endmodule

// File: tb/retskip_seq_bench.sv
module retskip_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] opcode_i = '0;
    logic [7:0]  sp_i = '0;
    logic [3:0]  flags_i = '0;
    logic        mem_rd_o;
    logic [7:0]  mem_addr_o;
    logic [3:0]  mem_rdata_i = '0;
    logic        busy_o, done_o;
    logic [7:0]  sp_o, step_o;
    logic [3:0]  page_o, flags_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] mem [256];

    always #10 clk = ~clk;

    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];

    retskip_seq u_retskip_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .sp_i(sp_i), .flags_i(flags_i), .mem_rd_o(mem_rd_o),
        .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o), .page_o(page_o),
        .step_o(step_o), .flags_o(flags_o)
    );

    // {sp, word@sp, word@sp+1, word@sp+2, flags}
    localparam int NV = 5;
    localparam logic [23:0] VEC [NV] = '{
        {8'hB0, 4'h6, 4'h0, 4'h0, 4'h5},
        {8'hFE, 4'hF, 4'hF, 4'hA, 4'hF},
        {8'h10, 4'h3, 4'hC, 4'h5, 4'h0},
        {8'hFD, 4'h1, 4'h2, 4'h3, 4'h9},
        {8'h7F, 4'hE, 4'h4, 4'hF, 4'h6}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] sp, input logic [3:0] n0, n1, n2,
                          input logic [3:0] fl, input bit hold_start);
        logic [7:0] exp_step;
        logic [7:0] exp_sp;
        int rd_count;
        mem[sp] = n0;
        mem[8'(sp + 8'd1)] = n1;
        mem[8'(sp + 8'd2)] = n2;
        exp_step = {n1, n0} + 8'd1;
        exp_sp   = sp + 8'd3;
        rd_count = 0;
        @(negedge clk);
        start_i = 1'b1; opcode_i = 12'hFDE; sp_i = sp; flags_i = fl;
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            if (!hold_start) start_i = 1'b0;
            else begin sp_i = 8'h55; flags_i = ~fl; end
            if (k == 1) chk(busy_o, "R2 busy after accept", busy_o, 1);
            if (k <= 12) chk(busy_o, "R8 busy in run", busy_o, 1);
            else         chk(!busy_o, "R8 busy low at 13", busy_o, 0);
            chk(done_o == (k == 12), "R8 done timing", done_o, (k == 12));
            if (k >= 2 && k <= 4) begin
                chk(mem_rd_o, "R4 strobe", mem_rd_o, 1);
                chk(mem_addr_o == 8'(sp + 8'(k - 2)), "R4 address", mem_addr_o, 8'(sp + 8'(k - 2)));
            end else begin
                chk(!mem_rd_o, "R4 no strobe", mem_rd_o, 0);
            end
            if (mem_rd_o) rd_count++;
            if (k >= 12) begin
                chk(step_o == exp_step, "R5 R7 step", step_o, exp_step);
                chk(page_o == n2, "R5 page", page_o, n2);
                chk(sp_o == exp_sp, "R6 sp", sp_o, exp_sp);
                chk(flags_o == fl, "R9 flags", flags_o, fl);
            end
        end
        start_i = 1'b0;
        if (hold_start) chk(rd_count == 3, "R10 one run only", rd_count, 3);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s0, t0;
        logic [3:0] p0, f0;
        for (int i = 0; i < 256; i++) mem[i] = 4'(i * 7);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !mem_rd_o, "R1 controls", {busy_o, done_o, mem_rd_o}, 0);
        chk(sp_o == 0 && page_o == 0 && step_o == 0 && flags_o == 0, "R1 results",
            {sp_o, page_o, step_o, flags_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++)
            run_op(VEC[v][23:16], VEC[v][15:12], VEC[v][11:8], VEC[v][7:4], VEC[v][3:0], 1'b0);
        // R3 wrong opcode ignored
        s0 = sp_o; t0 = step_o; p0 = page_o; f0 = flags_o;
        @(negedge clk);
        start_i = 1'b1; opcode_i = 12'hFDF; sp_i = 8'h22; flags_i = 4'h3;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(!busy_o && !mem_rd_o, "R3 stays idle", {busy_o, mem_rd_o}, 0);
            chk(sp_o == s0 && step_o == t0 && page_o == p0 && flags_o == f0, "R3 outputs kept",
                {sp_o, step_o, page_o, flags_o}, {s0, t0, p0, f0});
            @(negedge clk);
        end
        // R10 start and sp_i changes while busy ignored
        run_op(8'h40, 4'h9, 4'h8, 4'h2, 4'hC, 1'b1);
        // R7 wrap at top of step with page kept
        run_op(8'h00, 4'hF, 4'hF, 4'h3, 4'h1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule